// File: doc/BRIEF.md
# I2C Serial EEPROM Random-Read Sequencer

This block is a single-master I2C sequencer. On one command strobe it runs a complete bus transaction on its own and reports when the bus is idle again. It has two transaction forms.

The first form reads one byte at a random location of a serial EEPROM that has a 16-bit internal address. It first writes the location with a write-type control byte and two address bytes. It then issues a repeated START and a read-type control byte, and clocks in one data byte. It ends the read with a not-acknowledge and a STOP. The second form writes three bytes to a simple I2C device: an address byte, a fixed command byte of zero and a payload byte.

SCL is generated from the system clock through a programmable divider. Each bit time is split into four quarters of equal length. SDA is an open-drain line: the block only pulls it low or releases it, and reads the line back on `sda_i`. If the slave does not acknowledge any transmitted byte, the transaction is cut short with a STOP and an error flag is raised.

Top module: `i2c_eeprom_rdseq`

## Requirements
- R1: After reset and whenever no transaction is running, SCL is high, SDA is released (`sda_oe`=0), and `busy`, `done` and `ack_err` are 0.
- R2: Every bit slot lasts four quarters, and each quarter lasts `qtr_div`+1 clocks. In a START slot or a data/acknowledge slot, SCL is low in quarters 0 and 3 and high in quarters 1 and 2. In a STOP slot, SCL is low in quarter 0 and high in quarters 1 to 3. The first quarter begins on the clock edge that accepts the strobe.
- R3: While SCL stays high, SDA changes only in two places. In a START slot, SDA is released in quarters 0–1 and pulled low in quarters 2–3. In a STOP slot, SDA is pulled low in quarters 0–1 and released in quarters 2–3.
- R4: The EEPROM control byte is {4'b1010, `blk_sel`, `chip_sel`[1], `chip_sel`[0], rw}, where rw=0 marks a write and rw=1 marks a read.
- R5: With `rd_mode`=1, the slot sequence is START, control(rw=0), `mem_addr`[15:8], `mem_addr`[7:0], repeated START, control(rw=1), one received byte, STOP. Every byte is sent MSB first, one bit per slot, with SDA pulled low for a 0 bit.
- R6: The master releases SDA in the ninth slot of every byte. After a transmitted byte, a low line in that slot is taken as an acknowledge. After the received byte, the released line is the master's NACK.
- R7: The received byte is sampled MSB first in the middle of SCL high. When `done` is asserted it is presented on `rd_data`.
- R8: With `rd_mode`=0, the slot sequence is START, {`wr_dev`, 1'b0}, 8'h00, `wr_data`, STOP.
- R9: If SDA is sampled high in the acknowledge slot of any transmitted byte, the next slot is a STOP, no further byte is sent, and `ack_err` is set.
- R10: `done` is high for exactly one clock, on the clock after the STOP slot ends. At that point `busy` is 0. A strobe that arrives while `busy` is 1 is ignored.
- R11: `ack_err` is cleared when a new transaction is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, accepted when idle |
| rd_mode | input | 1 | 1: random EEPROM read, 0: three-byte write |
| chip_sel | input | 2 | Chip-address bits of the control byte |
| blk_sel | input | 1 | Block-select bit of the control byte |
| mem_addr | input | 16 | EEPROM location to read |
| wr_dev | input | 7 | Seven-bit device address for the write form |
| wr_data | input | 8 | Payload byte for the write form |
| qtr_div | input | DIVW | Quarter-bit length minus one, in clocks |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_o | output | 1 | SCL level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-clock pulse when the bus is free again |
| ack_err | output | 1 | Slave failed to acknowledge a byte |
| rd_data | output | 8 | Byte received by the last read |

## Verification
Take the clock edge that accepts the strobe. The first quarter of the START slot is visible right after that edge. Each quarter then holds for exactly `qtr_div`+1 clocks, so slot n of the transaction occupies the clocks 4·(`qtr_div`+1)·n to 4·(`qtr_div`+1)·(n+1)−1 after it. `done`, together with the final `rd_data` and `ack_err`, is due one clock after the last STOP quarter.

The bench builds the expected SCL/SDA/busy sequence for every clock from the slot list and compares it half a cycle after each edge. The slave's replies are also driven from this list, so acknowledge and data are stable for whole slots. The bench checks `done`, `rd_data` and `ack_err` in the single clock where they fall due, and checks that `done` is low again in the clock after.

// File: rtl/i2c_eeprom_rdseq.sv
module i2c_eeprom_rdseq #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            rd_mode,
  input  logic [1:0]      chip_sel,
  input  logic            blk_sel,
  input  logic [15:0]     mem_addr,
  input  logic [6:0]      wr_dev,
  input  logic [7:0]      wr_data,
  input  logic [DIVW-1:0] qtr_div,
  input  logic            sda_i,
  output logic            scl_o,
  output logic            sda_oe,
  output logic            busy,
  output logic            done,
  output logic            ack_err,
  output logic [7:0]      rd_data
);

  typedef enum logic [1:0] {T_STA, T_TX, T_RX, T_STO} tok_t;

  logic            mode_r, blk_r, nack_r;
  logic [1:0]      chip_r, q;
  logic [15:0]     addr_r;
  logic [6:0]      dev_r;
  logic [7:0]      wdat_r, sh, tx_byte;
  logic [DIVW-1:0] div_r, dcnt;
  logic [2:0]      step, stop_step;
  logic [3:0]      bitn;
  tok_t            tok;
  logic            tick;

  assign tick      = busy && (dcnt == div_r);
  assign stop_step = mode_r ? 3'd7 : 3'd4;

  always_comb begin
    tok     = T_STO;
    tx_byte = 8'h00;
    if (mode_r) begin
      case (step)
        3'd0, 3'd4: tok = T_STA;
        3'd1: begin tok = T_TX; tx_byte = {4'b1010, blk_r, chip_r, 1'b0}; end
        3'd2: begin tok = T_TX; tx_byte = addr_r[15:8]; end
        3'd3: begin tok = T_TX; tx_byte = addr_r[7:0]; end
        3'd5: begin tok = T_TX; tx_byte = {4'b1010, blk_r, chip_r, 1'b1}; end
        3'd6: tok = T_RX;
        default: tok = T_STO;
      endcase
    end else begin
      case (step)
        3'd0: tok = T_STA;
        3'd1: begin tok = T_TX; tx_byte = {dev_r, 1'b0}; end
        3'd2: begin tok = T_TX; tx_byte = 8'h00; end
        3'd3: begin tok = T_TX; tx_byte = wdat_r; end
        default: tok = T_STO;
      endcase
    end
  end

  always_comb begin
    scl_o  = 1'b1;
    sda_oe = 1'b0;
    if (busy) begin
      case (tok)
        T_STA: begin scl_o = q[0] ^ q[1]; sda_oe = q[1]; end
        T_TX:  begin scl_o = q[0] ^ q[1]; sda_oe = (bitn != 4'd8) && !tx_byte[3'd7 - bitn[2:0]]; end
        T_RX:  begin scl_o = q[0] ^ q[1]; sda_oe = 1'b0; end
        default: begin scl_o = (q != 2'd0); sda_oe = !q[1]; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; ack_err <= 1'b0; rd_data <= 8'h00;
      mode_r <= 1'b0; blk_r <= 1'b0; chip_r <= 2'd0; addr_r <= 16'h0;
      dev_r <= 7'h0; wdat_r <= 8'h0; div_r <= '0; dcnt <= '0;
      q <= 2'd0; step <= 3'd0; bitn <= 4'd0; sh <= 8'h0; nack_r <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1; ack_err <= 1'b0;
          mode_r <= rd_mode; blk_r <= blk_sel; chip_r <= chip_sel;
          addr_r <= mem_addr; dev_r <= wr_dev; wdat_r <= wr_data;
          div_r <= qtr_div; dcnt <= '0; q <= 2'd0; step <= 3'd0; bitn <= 4'd0;
        end
      end else begin
        dcnt <= tick ? '0 : dcnt + 1'b1;
        if (tick) begin
          q <= q + 2'd1;
          if (q == 2'd1) begin
            nack_r <= sda_i;
            if (tok == T_RX && bitn != 4'd8) sh <= {sh[6:0], sda_i};
          end
          if (q == 2'd3) begin
            case (tok)
              T_STA: step <= step + 3'd1;
              T_TX: begin
                if (bitn == 4'd8) begin
                  bitn <= 4'd0;
                  if (nack_r) begin
                    ack_err <= 1'b1;
                    step    <= stop_step;
                  end else step <= step + 3'd1;
                end else bitn <= bitn + 4'd1;
              end
              T_RX: begin
                if (bitn == 4'd8) begin
                  bitn <= 4'd0; rd_data <= sh; step <= step + 3'd1;
                end else bitn <= bitn + 4'd1;
              end
              default: begin busy <= 1'b0; done <= 1'b1; end
            endcase
          end
        end
      end
    end
  end

  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (scl_o && !sda_oe));

  p_quarter_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (dcnt <= div_r));

  p_sda_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && scl_o && $past(scl_o) && (sda_oe != $past(sda_oe)))
      |-> ((tok == T_STA && sda_oe) || (tok == T_STO && !sda_oe)));

  p_nack_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_err) |-> (busy && tok == T_STO));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && $past(tok == T_STO)));

  p_strobe_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(addr_r) && $stable(mode_r)));

endmodule

// File: tb/sim_i2c_eeprom_rdseq.sv
module sim_i2c_eeprom_rdseq;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, rd_mode, blk_sel, sda_i, scl_o, sda_oe, busy, done, ack_err;
  logic [1:0] chip_sel;
  logic [15:0] mem_addr;
  logic [6:0] wr_dev;
  logic [7:0] wr_data, qtr_div, rd_data;
  logic slave_pull = 1'b0;

  assign sda_i = ~(sda_oe | slave_pull);

  i2c_eeprom_rdseq #(.DIVW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_mode(rd_mode), .chip_sel(chip_sel),
    .blk_sel(blk_sel), .mem_addr(mem_addr), .wr_dev(wr_dev), .wr_data(wr_data),
    .qtr_div(qtr_div), .sda_i(sda_i), .scl_o(scl_o), .sda_oe(sda_oe), .busy(busy),
    .done(done), .ack_err(ack_err), .rd_data(rd_data));

  int checks = 0, failures = 0, cyc_all = 0, D = 1;
  bit qs[$]; bit qo[$]; bit qp[$]; int qk[$]; string qt[$];

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc_all);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // kind: 0 START, 1 bit slot, 2 STOP
  task automatic push_slot(int kind, bit oe, bit sp, string tag);
    for (int qq = 0; qq < 4; qq++) begin
      bit s, o;
      if (kind == 0) begin s = (qq == 1 || qq == 2); o = (qq >= 2); end
      else if (kind == 1) begin s = (qq == 1 || qq == 2); o = oe; end
      else begin s = (qq != 0); o = (qq < 2); end
      for (int k = 0; k < D; k++) begin
        qs.push_back(s); qo.push_back(o); qp.push_back(sp); qk.push_back(kind); qt.push_back(tag);
      end
    end
  endtask

  task automatic push_tx(logic [7:0] b, bit nack, string tag);
    for (int i = 7; i >= 0; i--) push_slot(1, !b[i], 1'b0, tag);
    push_slot(1, 1'b0, !nack, "R6");
  endtask

  task automatic push_rx(logic [7:0] b);
    for (int i = 7; i >= 0; i--) push_slot(1, 1'b0, !b[i], "R7");
    push_slot(1, 1'b0, 1'b0, "R6");
  endtask

  task automatic run(bit rd, logic [1:0] cs, bit blk, logic [15:0] a, logic [6:0] dv,
                     logic [7:0] wd, logic [7:0] mem_byte, int nack_at, int div, bit poke);
    logic [7:0] tx [4];
    int ntx;
    bit nacked = 0, prev_s, prev_o;
    D = div + 1;
    if (rd) begin
      tx[0] = {4'b1010, blk, cs, 1'b0}; tx[1] = a[15:8]; tx[2] = a[7:0];
      tx[3] = {4'b1010, blk, cs, 1'b1}; ntx = 4;
    end else begin
      tx[0] = {dv, 1'b0}; tx[1] = 8'h00; tx[2] = wd; tx[3] = 8'h00; ntx = 3;
    end
    push_slot(0, 1'b0, 1'b0, rd ? "R5" : "R8");
    for (int j = 0; j < ntx; j++) begin
      if (rd && j == 3) push_slot(0, 1'b0, 1'b0, "R5");
      push_tx(tx[j], j == nack_at, rd ? ((j == 0 || j == 3) ? "R4" : "R5") : "R8");
      if (j == nack_at) begin nacked = 1; break; end
    end
    if (rd && !nacked) push_rx(mem_byte);
    push_slot(2, 1'b0, 1'b0, nacked ? "R9" : "R10");

    @(negedge clk);
    rd_mode = rd; chip_sel = cs; blk_sel = blk; mem_addr = a; wr_dev = dv;
    wr_data = wd; qtr_div = 8'(div); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(ack_err == 1'b0, "R11", "ack_err after accept", ack_err, 0);
    prev_s = 1'b1; prev_o = 1'b0;
    for (int c = 0; qs.size() > 0; c++) begin
      bit es, eo, ep; int ek; string et;
      es = qs.pop_front(); eo = qo.pop_front(); ep = qp.pop_front();
      ek = qk.pop_front(); et = qt.pop_front();
      slave_pull = ep;
      if (scl_o !== es) chk(0, "R2", "scl", scl_o, es);
      if (sda_oe !== eo) chk(0, et, "sda_oe", sda_oe, eo);
      if (busy !== 1'b1 || done !== 1'b0) chk(0, "R10", "busy/done", {busy, done}, 2);
      if (scl_o && prev_s && (sda_oe != prev_o))
        chk(ek != 1, "R3", "sda change under scl high", ek, 0);
      prev_s = scl_o; prev_o = sda_oe;
      if (poke && c == 20) begin
        start = 1'b1; rd_mode = !rd; mem_addr = ~a; wr_data = ~wd; chip_sel = ~cs;
      end else if (poke && c == 21) begin
        start = 1'b0; rd_mode = rd; mem_addr = a; wr_data = wd; chip_sel = cs;
      end
      @(negedge clk);
    end
    slave_pull = 1'b0;
    chk(done === 1'b1 && busy === 1'b0, "R10", "done pulse due", {done, busy}, 2);
    chk(ack_err === nacked, "R9", "ack_err", ack_err, nacked);
    chk(scl_o === 1'b1 && sda_oe === 1'b0, "R1", "bus free", {scl_o, sda_oe}, 2);
    if (rd && !nacked) chk(rd_data === mem_byte, "R7", "rd_data", rd_data, mem_byte);
    @(negedge clk);
    chk(done === 1'b0, "R10", "done single cycle", done, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; rd_mode = 1'b0; chip_sel = 2'd0; blk_sel = 1'b0;
    mem_addr = 16'h0; wr_dev = 7'h0; wr_data = 8'h0; qtr_div = 8'd1;
    repeat (3) @(negedge clk);
    chk(scl_o === 1'b1 && sda_oe === 1'b0 && busy === 1'b0 && done === 1'b0 && ack_err === 1'b0,
        "R1", "reset state", {scl_o, sda_oe, busy, done, ack_err}, 5'b10000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(scl_o === 1'b1 && sda_oe === 1'b0 && busy === 1'b0, "R1", "idle after reset",
        {scl_o, sda_oe, busy}, 3'b100);
    run(1, 2'b11, 1, 16'h80F0, 7'h00, 8'h00, 8'hA5, -1, 1, 0);
    run(1, 2'b01, 0, 16'h1234, 7'h00, 8'h00, 8'h3C, -1, 0, 0);
    run(0, 2'b00, 0, 16'h0000, 7'h2F, 8'h5A, 8'h00, -1, 2, 0);
    run(1, 2'b10, 1, 16'hBEEF, 7'h00, 8'h00, 8'h77, 0, 1, 0);
    run(1, 2'b00, 0, 16'h00FF, 7'h00, 8'h00, 8'h77, 3, 0, 0);
    run(0, 2'b00, 0, 16'h0000, 7'h51, 8'hC3, 8'h00, 2, 0, 0);
    run(1, 2'b01, 1, 16'hFF00, 7'h00, 8'h00, 8'h81, -1, 1, 1);
    run(0, 2'b00, 0, 16'h0000, 7'h7F, 8'hFF, 8'h00, -1, 3, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule